// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Engine

This block is the network layer of a 1-Wire slave. A bit-level front end handles line timing. It passes the engine one event per time slot: a received bit from a master write slot, a completed transmit for a master read slot, or a reset strobe with a flag that says whether the reset pulse was long or short. After each reset the engine takes in one 8-bit ROM command, least significant bit first. It then runs that command against a fixed 64-bit identity. The commands cover reading the identity, matching it, the bitwise search arbitration, skipping addressing, and two variants that also switch the link to overdrive speed.

The identity holds a family code, a serial number and a CRC-8. The CRC is computed from the parameters when the design is elaborated, so each instance carries an identity that is consistent with itself. The engine holds the overdrive flag for the front end. It raises a select signal once a ROM command has completed successfully, and that signal is what allows the memory-function layer above it to run. A slave that loses arbitration, fails a match or sees an unknown code goes inactive and waits for the next reset.

The front end reads `tx_en_o` to decide the slot type. When it is high, the slot is a read slot and the front end drives `tx_bit_o`, where 0 pulls the line low. When it is low, the front end samples the line and pulses `rx_valid_i`.

Top module: `ow_rom_engine`

## Requirements
- R1: After `rst_ni` is released, and until the first reset strobe, the engine is inactive: `sel_o`=0, `od_o`=0, `tx_en_o`=0.
- R2: The identity is sent least significant bit first. Bits 0-7 hold the family code (default 0x0F). Bits 8-55 hold the serial number. Bits 56-63 hold a CRC of bits 0-55 with polynomial x^8+x^5+x^4+1, starting from zero. Running that CRC over all 64 bits gives zero.
- R3: Any reset strobe clears `sel_o` and `tx_en_o` and returns the engine to command reception. The next 8 received bits form the command, LSB first.
- R4: Read ROM (0x33): the next 64 read slots return the identity, and `sel_o` rises after the last one.
- R5: Skip ROM (0xCC): `sel_o` rises once the command byte completes, and `od_o` is unchanged.
- R6: Match ROM (0x55): the next 64 received bits are compared with the identity. If all of them match, `sel_o` rises. On any mismatch the engine goes inactive (`sel_o`=0, `tx_en_o`=0, later slots ignored) until a reset.
- R7: Search ROM (0xF0): for each identity bit, the engine sends the bit, then its complement, then receives the master's direction bit. If the direction differs from its own bit, the engine goes inactive until a reset. After all 64 bits it raises `sel_o`.
- R8: Overdrive skip (0x3C): `od_o` and `sel_o` rise once the command byte completes.
- R9: Overdrive match (0x69): `od_o` rises once the command byte completes, then the identity is matched as in R6. On a mismatch `od_o` returns to the value it had before the command.
- R10: Any other command code leaves the engine inactive until the next reset strobe.
- R11: A long reset strobe clears `od_o`. A short reset strobe leaves it unchanged.
- R12: `tx_en_o` is high only in slots where the engine transmits. `tx_bit_o` is 1 whenever `tx_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_stb_i | input | 1 | Bus reset detected, one-cycle strobe |
| rst_long_i | input | 1 | Qualifies `rst_stb_i`: the reset pulse was long |
| rx_valid_i | input | 1 | Master write slot completed, one-cycle strobe |
| rx_bit_i | input | 1 | Bit value of the write slot |
| tx_done_i | input | 1 | Master read slot completed, one-cycle strobe |
| tx_en_o | output | 1 | Next slot is a read slot driven by this engine |
| tx_bit_o | output | 1 | Bit to send in the read slot (0 pulls the line low) |
| od_o | output | 1 | Overdrive speed flag |
| sel_o | output | 1 | ROM layer complete; memory functions allowed |

## Verification
The bench builds two instances with the default family code and two different 48-bit serials. Both instances hang on a wired-AND bus. The serials differ at many bit positions, so a search run meets a real discrepancy that the master must resolve over two passes. A single identity sent to both instances fails one of them early and passes the other, and a copy of the identity with the final CRC bit flipped fails at bit 63. The bench can also address one instance alone, which gives access to the exact bit and complement sequence of the search and to overdrive match from both speeds.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  localparam int CRC_W = 8;
  // x^8+x^5+x^4+1, bit-reversed for LSB-first shifting
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 8'h8C;

  localparam logic [7:0] OP_READ     = 8'h33;
  localparam logic [7:0] OP_MATCH    = 8'h55;
  localparam logic [7:0] OP_SEARCH   = 8'hF0;
  localparam logic [7:0] OP_SKIP     = 8'hCC;
  localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [7:0] OP_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_MATCH, CMD_SEARCH, CMD_SKIP, CMD_OD_SKIP, CMD_OD_MATCH
  } rom_cmd_e;

  typedef enum logic [2:0] {
    ST_HALT, ST_CMD, ST_SEND, ST_CMP, ST_SR_BIT, ST_SR_INV, ST_SR_DIR, ST_SEL
  } eng_st_e;

  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_REV : '0);
  endfunction

endpackage

// File: rtl/ow_id_rom.sv
module ow_id_rom
  import ow_rom_pkg::*;
#(
  parameter int               FAM_W  = 8,
  parameter int               SER_W  = 48,
  parameter logic [FAM_W-1:0] FAMILY = 8'h0F,
  parameter logic [SER_W-1:0] SERIAL = 48'h3A5C_0012_F0E1,
  localparam int              DATA_W = FAM_W + SER_W,
  localparam int              ID_W   = DATA_W + CRC_W
) (
  output logic [ID_W-1:0] id_o
);

  logic [DATA_W-1:0] data;
  logic [CRC_W-1:0]  chain [DATA_W+1];

  assign data     = {SERIAL, FAMILY};
  assign chain[0] = '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_crc
    assign chain[i+1] = crc8_step(chain[i], data[i]);
  end

  assign id_o = {chain[DATA_W], data};

endmodule

// File: rtl/ow_cmd_decode.sv
module ow_cmd_decode
  import ow_rom_pkg::*;
(
  input  logic [7:0] code_i,
  output rom_cmd_e   cmd_o
);

  always_comb begin
    unique case (code_i)
      OP_READ:     cmd_o = CMD_READ;
      OP_MATCH:    cmd_o = CMD_MATCH;
      OP_SEARCH:   cmd_o = CMD_SEARCH;
      OP_SKIP:     cmd_o = CMD_SKIP;
      OP_OD_SKIP:  cmd_o = CMD_OD_SKIP;
      OP_OD_MATCH: cmd_o = CMD_OD_MATCH;
      default:     cmd_o = CMD_NONE;
    endcase
  end

endmodule

// File: rtl/ow_bit_ctr.sv
module ow_bit_ctr #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/ow_rom_engine.sv
module ow_rom_engine
  import ow_rom_pkg::*;
#(
  parameter int               FAM_W  = 8,
  parameter int               SER_W  = 48,
  parameter logic [FAM_W-1:0] FAMILY = 8'h0F,
  parameter logic [SER_W-1:0] SERIAL = 48'h3A5C_0012_F0E1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_stb_i,
  input  logic rst_long_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic tx_done_i,
  output logic tx_en_o,
  output logic tx_bit_o,
  output logic od_o,
  output logic sel_o
);

  localparam int ID_W  = FAM_W + SER_W + CRC_W;
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(7);
  localparam logic [IDX_W-1:0] ID_LAST   = IDX_W'(ID_W - 1);

  logic [ID_W-1:0]  id;
  logic [IDX_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;
  rom_cmd_e         cmd;
  eng_st_e          st_q, st_d;
  logic [6:0]       sr_q, sr_d;
  logic             od_q, od_d;
  logic             od_keep_q, od_keep_d;
  logic             odm_q, odm_d;
  logic             id_bit, byte_last, id_last;

  ow_id_rom #(
    .FAM_W (FAM_W),
    .SER_W (SER_W),
    .FAMILY(FAMILY),
    .SERIAL(SERIAL)
  ) u_id (
    .id_o(id)
  );

  ow_bit_ctr #(.W(IDX_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  ow_cmd_decode u_dec (
    .code_i({rx_bit_i, sr_q}),
    .cmd_o (cmd)
  );

  assign id_bit    = id[cnt];
  assign byte_last = (cnt == BYTE_LAST);
  assign id_last   = (cnt == ID_LAST);

  always_comb begin
    st_d      = st_q;
    sr_d      = sr_q;
    od_d      = od_q;
    od_keep_d = od_keep_q;
    odm_d     = odm_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    if (rst_stb_i) begin
      st_d    = ST_CMD;
      cnt_clr = 1'b1;
      odm_d   = 1'b0;
      if (rst_long_i) od_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_CMD: if (rx_valid_i) begin
          sr_d    = {rx_bit_i, sr_q[6:1]};
          cnt_inc = 1'b1;
          if (byte_last) begin
            cnt_clr = 1'b1;
            unique case (cmd)
              CMD_READ:    st_d = ST_SEND;
              CMD_MATCH:   st_d = ST_CMP;
              CMD_SEARCH:  st_d = ST_SR_BIT;
              CMD_SKIP:    st_d = ST_SEL;
              CMD_OD_SKIP: begin
                st_d = ST_SEL;
                od_d = 1'b1;
              end
              CMD_OD_MATCH: begin
                st_d      = ST_CMP;
                od_keep_d = od_q;
                odm_d     = 1'b1;
                od_d      = 1'b1;
              end
              default:     st_d = ST_HALT;
            endcase
          end
        end
        ST_SEND: if (tx_done_i) begin
          if (id_last) begin
            st_d    = ST_SEL;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_CMP: if (rx_valid_i) begin
          if (rx_bit_i != id_bit) begin
            st_d = ST_HALT;
            if (odm_q) od_d = od_keep_q;
          end else if (id_last) begin
            st_d    = ST_SEL;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_SR_BIT: if (tx_done_i) st_d = ST_SR_INV;
        ST_SR_INV: if (tx_done_i) st_d = ST_SR_DIR;
        ST_SR_DIR: if (rx_valid_i) begin
          if (rx_bit_i != id_bit) begin
            st_d = ST_HALT;
          end else if (id_last) begin
            st_d    = ST_SEL;
            cnt_clr = 1'b1;
          end else begin
            st_d    = ST_SR_BIT;
            cnt_inc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_HALT;
      sr_q      <= '0;
      od_q      <= 1'b0;
      od_keep_q <= 1'b0;
      odm_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      sr_q      <= sr_d;
      od_q      <= od_d;
      od_keep_q <= od_keep_d;
      odm_q     <= odm_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_SEND, ST_SR_BIT: tx_bit_o = id_bit;
      ST_SR_INV:          tx_bit_o = ~id_bit;
      default:            tx_bit_o = 1'b1;
    endcase
  end

  assign tx_en_o = (st_q == ST_SEND) || (st_q == ST_SR_BIT) || (st_q == ST_SR_INV);
  assign od_o    = od_q;
  assign sel_o   = (st_q == ST_SEL);

endmodule

// File: rtl/ow_rom_engine_chk.sv
module ow_rom_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_stb_i,
  input logic rst_long_i,
  input logic rx_valid_i,
  input logic tx_en_o,
  input logic tx_bit_o,
  input logic od_o,
  input logic sel_o
);

  // R11
  od_long_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_stb_i && rst_long_i |=> !od_o);

  // R11
  od_short_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_stb_i && !rst_long_i |=> od_o == $past(od_o));

  // R3
  reset_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_stb_i |=> !sel_o && !tx_en_o);

  // R12
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> tx_bit_o);

  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_o) |-> $past(rst_stb_i));

  // R8
  od_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(od_o) |-> $past(rx_valid_i));

  // R12
  tx_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> !tx_en_o);

endmodule

bind ow_rom_engine ow_rom_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_stb_i (rst_stb_i),
  .rst_long_i(rst_long_i),
  .rx_valid_i(rx_valid_i),
  .tx_en_o   (tx_en_o),
  .tx_bit_o  (tx_bit_o),
  .od_o      (od_o),
  .sel_o     (sel_o)
);

// File: tb/sim_ow_rom_engine.sv
`timescale 1ns/1ps
module sim_ow_rom_engine;

  localparam logic [47:0] SER0 = 48'h3A5C_0012_F0E1;
  localparam logic [47:0] SER1 = 48'h1B7E_44D0_0C93;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rst_stb = '0, rst_long = '0, rx_valid = '0, rx_bit = '0, tx_done = '0;
  logic [1:0] tx_en, tx_bit, od, sel;
  int n_chk = 0, n_fail = 0;
  logic [63:0] id0, id1;

  always #5 clk = ~clk;

  ow_rom_engine #(.SERIAL(SER0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rst_stb_i(rst_stb[0]), .rst_long_i(rst_long[0]),
    .rx_valid_i(rx_valid[0]), .rx_bit_i(rx_bit[0]), .tx_done_i(tx_done[0]),
    .tx_en_o(tx_en[0]), .tx_bit_o(tx_bit[0]), .od_o(od[0]), .sel_o(sel[0]));

  ow_rom_engine #(.SERIAL(SER1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .rst_stb_i(rst_stb[1]), .rst_long_i(rst_long[1]),
    .rx_valid_i(rx_valid[1]), .rx_bit_i(rx_bit[1]), .tx_done_i(tx_done[1]),
    .tx_en_o(tx_en[1]), .tx_bit_o(tx_bit[1]), .od_o(od[1]), .sel_o(sel[1]));

  function automatic logic [7:0] crc_bits(input logic [63:0] d, input int n);
    logic [7:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic m = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (m) c = c ^ 8'b1000_1100;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id(input logic [47:0] s);
    logic [63:0] t = {8'h00, s, 8'h0F};
    t[63:56] = crc_bits(t, 56);
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_reset(input logic [1:0] m, input logic lng);
    @(negedge clk); rst_stb = m; rst_long = {2{lng}};
    @(negedge clk); rst_stb = '0; rst_long = '0;
  endtask

  task automatic wr_bit(input logic [1:0] m, input logic b);
    @(negedge clk); rx_valid = m; rx_bit = {2{b}};
    @(negedge clk); rx_valid = '0;
  endtask

  task automatic rd_bit(input logic [1:0] m, output logic b);
    @(negedge clk); b = &(tx_bit | ~m); tx_done = m;
    @(negedge clk); tx_done = '0;
  endtask

  task automatic wr_byte(input logic [1:0] m, input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(m, v[i]);
  endtask

  task automatic wr_id(input logic [1:0] m, input logic [63:0] v);
    for (int i = 0; i < 64; i++) wr_bit(m, v[i]);
  endtask

  task automatic rd_id(input logic [1:0] m, output logic [63:0] v);
    for (int i = 0; i < 64; i++) begin
      logic b;
      rd_bit(m, b);
      v[i] = b;
    end
  endtask

  task automatic t_reset_state();
    check(sel == 2'b00, "R1 sel", 64'(sel), 0);
    check(od == 2'b00, "R1 od", 64'(od), 0);
    check(tx_en == 2'b00, "R1 tx_en", 64'(tx_en), 0);
    check(tx_bit == 2'b11, "R12 idle bit", 64'(tx_bit), 3);
  endtask

  task automatic t_read_rom();
    logic [63:0] v;
    bus_reset(2'b01, 1'b1);
    wr_byte(2'b01, 8'h33);
    check(tx_en[0] == 1'b1, "R12 tx_en on read", 64'(tx_en[0]), 1);
    rd_id(2'b01, v);
    check(v == id0, "R4 id0", v, id0);
    check(v[7:0] == 8'h0F, "R2 family", 64'(v[7:0]), 64'h0F);
    check(crc_bits(v, 64) == 8'h00, "R2 crc residue", 64'(crc_bits(v, 64)), 0);
    check(sel[0] == 1'b1, "R4 sel", 64'(sel[0]), 1);
    bus_reset(2'b10, 1'b1);
    wr_byte(2'b10, 8'h33);
    rd_id(2'b10, v);
    check(v == id1, "R4 id1", v, id1);
  endtask

  task automatic t_skip();
    bus_reset(2'b11, 1'b1);
    wr_byte(2'b11, 8'hCC);
    check(sel == 2'b11, "R5 sel", 64'(sel), 3);
    check(od == 2'b00, "R5 od", 64'(od), 0);
    bus_reset(2'b11, 1'b0);
    check(sel == 2'b00, "R3 reset clears sel", 64'(sel), 0);
  endtask

  task automatic t_match();
    logic [63:0] bad;
    bus_reset(2'b11, 1'b1);
    wr_byte(2'b11, 8'h55);
    wr_id(2'b11, id0);
    check(sel == 2'b01, "R6 match selects one", 64'(sel), 1);
    wr_byte(2'b11, 8'hCC);
    check(sel[1] == 1'b0 && tx_en[1] == 1'b0, "R6 dropped stays inactive",
          64'({sel[1], tx_en[1]}), 0);
    bad = id1;
    bad[63] = ~bad[63];
    bus_reset(2'b11, 1'b1);
    wr_byte(2'b11, 8'h55);
    wr_id(2'b11, bad);
    check(sel == 2'b00, "R6 last-bit mismatch", 64'(sel), 0);
  endtask

  task automatic t_unknown();
    bus_reset(2'b01, 1'b1);
    wr_byte(2'b01, 8'hA5);
    wr_byte(2'b01, 8'hCC);
    check(sel[0] == 1'b0 && tx_en[0] == 1'b0, "R10 unknown halts", 64'({sel[0], tx_en[0]}), 0);
    bus_reset(2'b01, 1'b0);
    wr_byte(2'b01, 8'hCC);
    check(sel[0] == 1'b1, "R3 command after reset", 64'(sel[0]), 1);
  endtask

  task automatic t_overdrive();
    bus_reset(2'b01, 1'b1);
    wr_byte(2'b01, 8'h3C);
    check(od[0] == 1'b1 && sel[0] == 1'b1, "R8 od skip", 64'({od[0], sel[0]}), 3);
    bus_reset(2'b01, 1'b0);
    check(od[0] == 1'b1, "R11 short keeps od", 64'(od[0]), 1);
    bus_reset(2'b01, 1'b1);
    check(od[0] == 1'b0, "R11 long clears od", 64'(od[0]), 0);
  endtask

  task automatic t_od_match();
    bus_reset(2'b11, 1'b1);
    wr_byte(2'b11, 8'h69);
    check(od == 2'b11, "R9 od after byte", 64'(od), 3);
    wr_id(2'b11, id0);
    check(od == 2'b01 && sel == 2'b01, "R9 regular-speed mismatch falls back",
          64'({od, sel}), 64'h5);
    bus_reset(2'b10, 1'b1);
    wr_byte(2'b10, 8'h3C);
    bus_reset(2'b10, 1'b0);
    wr_byte(2'b10, 8'h69);
    wr_id(2'b10, id0);
    check(od[1] == 1'b1 && sel[1] == 1'b0, "R9 overdrive mismatch keeps od",
          64'({od[1], sel[1]}), 2);
  endtask

  task automatic t_search_single();
    int errs;
    logic b, c;
    errs = 0;
    bus_reset(2'b01, 1'b1);
    wr_byte(2'b01, 8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd_bit(2'b01, b);
      rd_bit(2'b01, c);
      if (b != id0[i] || c != ~id0[i]) errs++;
      wr_bit(2'b01, b);
    end
    check(errs == 0, "R7 bit/complement sequence", 64'(errs), 0);
    check(sel[0] == 1'b1, "R7 search select", 64'(sel[0]), 1);
    bus_reset(2'b01, 1'b1);
    wr_byte(2'b01, 8'hF0);
    for (int i = 0; i < 6; i++) begin
      rd_bit(2'b01, b);
      rd_bit(2'b01, c);
      wr_bit(2'b01, (i == 5) ? ~b : b);
    end
    check(tx_en[0] == 1'b0 && sel[0] == 1'b0, "R7 dropout", 64'({tx_en[0], sel[0]}), 0);
  endtask

  task automatic t_search_enum();
    logic [63:0] found [2];
    logic [63:0] prev;
    int last_disc, passes, sel_err;
    logic b, c, dir;
    last_disc = -1;
    passes = 0;
    sel_err = 0;
    prev = '0;
    found[0] = '0;
    found[1] = '0;
    do begin
      int last_zero;
      last_zero = -1;
      bus_reset(2'b11, 1'b0);
      wr_byte(2'b11, 8'hF0);
      for (int i = 0; i < 64; i++) begin
        rd_bit(2'b11, b);
        rd_bit(2'b11, c);
        if (b != c) dir = b;
        else begin
          if (i < last_disc) dir = prev[i];
          else dir = (i == last_disc);
          if (!dir) last_zero = i;
        end
        wr_bit(2'b11, dir);
        prev[i] = dir;
      end
      if (passes < 2) found[passes] = prev;
      if (sel != {prev == id1, prev == id0}) sel_err++;
      last_disc = last_zero;
      passes++;
    end while (last_disc != -1 && passes < 4);
    check(passes == 2, "R7 search pass count", 64'(passes), 2);
    check((found[0] == id0 && found[1] == id1) || (found[0] == id1 && found[1] == id0),
          "R7 enumerated ids", found[0] ^ found[1], id0 ^ id1);
    check(sel_err == 0, "R7 winner selected", 64'(sel_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    id0 = make_id(SER0);
    id1 = make_id(SER1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_rom();
    t_skip();
    t_match();
    t_unknown();
    t_overdrive();
    t_od_match();
    t_search_single();
    t_search_enum();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule